// File: doc/BRIEF.md
# Delay Code Programming Interface

This block holds the 8-bit code that sets a programmable delay element. Code 0 selects the shortest (inherent) delay, and each count above zero adds one equal step, up to 255 steps. The block takes slow, asynchronous programming pins and runs them through a synchronizer into a fast system clock. A mode pin picks the loading path. With mode at 1, the parallel pins either drive the code continuously while enable stays high, or set it at the moment enable falls. With mode at 0, a serial clock shifts data into an internal 8-bit register while enable is high. The old contents leave MSB first on a serial output, so several units can be chained, and the new code takes effect when enable falls.

A small state machine controls the loading. `ST_IDLE` is the state while enable is low. `ST_PAR` is the parallel-follow state, entered from `ST_IDLE` when enable is seen high and mode is 1. `ST_SER` is the serial-shift state, entered from `ST_IDLE` when enable is seen high and mode is 0. On the enable fall, `ST_PAR` returns to `ST_IDLE` and captures the pins. On the enable fall, `ST_SER` returns to `ST_IDLE` and commits the shift register to the active code. The mode pin is only read in `ST_IDLE`. A one-cycle update strobe marks every change of the active code.

Top module: `dlyc_if`

## Requirements
- R1: After reset, the active code is 0, the update strobe is 0, the serial output enable is 0, and the shift register holds 0. The register contents are seen as 0 bits on the first serial read.
- R2: With mode 1 and enable held high, the active code follows the parallel pins. Bit 7 of the pins is the code MSB.
- R3: With mode 1 and enable pulsed, the code takes the pin value present when enable falls. Later pin changes while enable is low leave the code unchanged.
- R4: With mode 0 and enable high, each rising serial-clock edge shifts the serial input into the register LSB. After eight edges, the first bit sent is the MSB.
- R5: In serial mode the active code does not change while bits are shifted. It takes the register value when enable falls.
- R6: In serial mode, the serial output shows register bit 7 once enable is high and before any clock edge. Each rising clock edge then presents the next lower old bit. After eight edges the output shows the newly written MSB, so the old contents are gone.
- R7: The serial output enable is 1 only in the serial-shift state. It is 0 while enable is low and in parallel mode.
- R8: Serial-clock edges while enable is low do not alter the shift register.
- R9: The mode is taken when enable rises. Mode changes while enable is high have no effect until enable falls: the parallel pins keep driving the code, and serial-clock edges do not shift.
- R10: The update strobe is high for exactly one cycle each time the active code changes value. It stays low when the same value is loaded again.
- R11: A parallel pin change in follow mode reaches the active code and the update strobe on the third rising system-clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than all programming pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Loading path: 1 = parallel, 0 = serial |
| en_i | input | 1 | Programming enable |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data input |
| par_i | input | 8 | Parallel code pins, bit 7 = MSB |
| code_o | output | 8 | Active delay code |
| upd_o | output | 1 | One-cycle pulse on code change |
| sdo_o | output | 1 | Serial data output (old register bits, MSB first) |
| sdo_oe_o | output | 1 | Drive enable for the serial output; 0 means high impedance |

## Verification
Every pin passes through two synchronizer flops. One more register then holds the state, the active code and the shift register. So a pin change shows on `code_o`, `upd_o` or `sdo_o` after the third rising edge. An enable rise needs one more edge before the state-dependent behaviour starts.

The bench changes pins just after a falling clock edge and samples on falling edges. The latency check on R11 samples exactly two and three falling edges after the stimulus. All other checks wait at least six cycles, so they do not depend on the exact cycle. The scoreboard monitor pops an expected code on every strobe, whenever it occurs. It reports any strobe with no expected value queued as a failure, and it checks at the end that the queue is empty.

// File: rtl/dlyc_pkg.sv
`timescale 1ns/1ps
package dlyc_pkg;
    // Loading-control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // enable low, nothing loads
        ST_PAR  = 2'd1,   // parallel pins drive the code
        ST_SER  = 2'd2    // serial shifting, output driven
    } ctl_state_e;
endpackage

// File: rtl/dlyc_sync.sv
`timescale 1ns/1ps
module dlyc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dlyc_ctrl.sv
`timescale 1ns/1ps
module dlyc_ctrl
    import dlyc_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_s,
    input  logic              en_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [CODE_W-1:0] par_s,
    output logic              ld_en,
    output logic [CODE_W-1:0] ld_val,
    output logic              sdo,
    output logic              sdo_oe
);
    ctl_state_e        state_q, state_d;
    logic              sclk_d;
    logic              sclk_rise;
    logic              shift_en;
    logic [CODE_W-1:0] sr_q;

    assign sclk_rise = sclk_s & ~sclk_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_s)  state_d = mode_s ? ST_PAR : ST_SER;
            ST_PAR:  if (!en_s) state_d = ST_IDLE;
            ST_SER:  if (!en_s) state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        ld_en    = 1'b0;
        ld_val   = par_s;
        sdo_oe   = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PAR: begin
                ld_en  = 1'b1;      // follow; last value kept at fall
                ld_val = par_s;
            end
            ST_SER: begin
                sdo_oe   = 1'b1;
                shift_en = en_s & sclk_rise;
                if (!en_s) begin
                    ld_en  = 1'b1;  // commit on enable fall
                    ld_val = sr_q;
                end
            end
            default: ;
        endcase
    end

    // Shift register and clock-edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sr_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (shift_en) sr_q <= {sr_q[CODE_W-2:0], sdi_s};
        end
    end

    assign sdo = sr_q[CODE_W-1];

    // R4: a granted shift moves the register up by one and inserts the serial bit
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shift_en) |-> sr_q == {$past(sr_q[CODE_W-2:0]), $past(sdi_s)});

    // R8: the register only changes after a cycle spent shifting
    p_sr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sr_q) |-> $past(state_q == ST_SER));

    // R9: parallel mode never switches straight to serial shifting
    p_mode_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PAR |=> state_q != ST_SER);
endmodule

// File: rtl/dlyc_if.sv
`timescale 1ns/1ps
module dlyc_if #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              en_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [CODE_W-1:0] par_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    localparam int SYNC_W = CODE_W + 4;

    logic [SYNC_W-1:0] pins_s;
    logic              ld_en;
    logic [CODE_W-1:0] ld_val;
    logic [CODE_W-1:0] code_q;
    logic              upd_q;

    dlyc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mode_i, en_i, sclk_i, sdi_i, par_i}),
        .q     (pins_s)
    );

    dlyc_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_s (pins_s[CODE_W+3]),
        .en_s   (pins_s[CODE_W+2]),
        .sclk_s (pins_s[CODE_W+1]),
        .sdi_s  (pins_s[CODE_W]),
        .par_s  (pins_s[CODE_W-1:0]),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .sdo    (sdo_o),
        .sdo_oe (sdo_oe_o)
    );

    // Active code and change strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= ld_en && (ld_val != code_q);
            if (ld_en) code_q <= ld_val;
        end
    end

    assign code_o = code_q;
    assign upd_o  = upd_q;

    // R10: a strobe always coincides with a new code value
    p_upd_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> code_o != $past(code_o));

    // R10: no strobe means the code held
    p_upd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(code_o));

    // R5: the code moves only when the controller asked for a load
    p_code_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> $past(ld_en));
endmodule

// File: tb/dlyc_if_tb.sv
`timescale 1ns/1ps
module dlyc_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0, en_i = 1'b0, sclk_i = 1'b0, sdi_i = 1'b0;
    logic [7:0] par_i = 8'h00;
    logic [7:0] code_o;
    logic       upd_o, sdo_o, sdo_oe_o;

    always #2.5 clk = ~clk;

    dlyc_if u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(en_i),
        .sclk_i(sclk_i), .sdi_i(sdi_i), .par_i(par_i),
        .code_o(code_o), .upd_o(upd_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );

    typedef struct {
        logic [7:0] code;
        string      tag;
    } exp_t;

    exp_t       expq[$];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;
    logic [7:0] mdl_code = 8'h00;
    logic [7:0] mdl_sr   = 8'h00;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard
    task automatic expect_code(input logic [7:0] v, input string tag);
        exp_t e;
        if (v != mdl_code) begin
            e.code = v;
            e.tag  = tag;
            expq.push_back(e);
        end
        mdl_code = v;
    endtask

    // Monitor: every strobe must match the next expected code
    always @(negedge clk) begin
        if (rst_n && !done && upd_o) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected strobe actual=%h expected=none", code_o);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (code_o !== e.code) begin
                    fails++;
                    $display("FAIL %s strobe code actual=%h expected=%h", e.tag, code_o, e.code);
                end
            end
        end
    end

    // Serial write; checks old bits on the serial output (R6)
    task automatic ser_write(input logic [7:0] v, input string tag);
        mode_i = 1'b0;
        en_i   = 1'b1;
        wait_n(6);
        chk({tag, " R7 oe in serial"}, {7'd0, sdo_oe_o}, 8'h01);
        for (int i = 7; i >= 0; i--) begin
            chk({tag, " R6 old bit"}, {7'd0, sdo_o}, {7'd0, mdl_sr[i]});
            sdi_i = v[i];
            wait_n(3);
            sclk_i = 1'b1;
            wait_n(4);
            sclk_i = 1'b0;
            wait_n(3);
        end
        chk({tag, " R6 new msb"}, {7'd0, sdo_o}, {7'd0, v[7]});
        chk({tag, " R5 code held while shifting"}, code_o, mdl_code);
        expect_code(v, {tag, " R4 R5 commit"});
        mdl_sr = v;
        en_i = 1'b0;
        wait_n(6);
        chk({tag, " R7 oe idle"}, {7'd0, sdo_oe_o}, 8'h00);
        chk({tag, " R5 committed code"}, code_o, v);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        wait_n(5);
        chk("R1 code", code_o, 8'h00);
        chk("R1 upd", {7'd0, upd_o}, 8'h00);
        chk("R1 oe", {7'd0, sdo_oe_o}, 8'h00);
        rst_n = 1'b1;
        wait_n(4);

        // R4 R6: first write reads out reset zeros; second reads back A5
        ser_write(8'hA5, "R1 R4");
        ser_write(8'h3C, "R4 R6 readback");

        // R8: clock edges with enable low
        sdi_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sclk_i = 1'b1; wait_n(4);
            sclk_i = 1'b0; wait_n(4);
        end
        chk("R8 code unchanged", code_o, 8'h3C);
        // R8 via readback, R10 same value gives no strobe
        ser_write(8'h3C, "R8 R10");

        // R2 transparent parallel
        mode_i = 1'b1;
        en_i   = 1'b1;
        expect_code(8'h11, "R2");
        par_i = 8'h11;
        wait_n(6);
        chk("R2 follow", code_o, 8'h11);
        chk("R7 oe parallel", {7'd0, sdo_oe_o}, 8'h00);

        // R11 latency
        expect_code(8'h80, "R11");
        par_i = 8'h80;
        wait_n(2);
        chk("R11 old before third edge", code_o, 8'h11);
        wait_n(1);
        chk("R11 new at third edge", code_o, 8'h80);
        chk("R11 strobe at third edge", {7'd0, upd_o}, 8'h01);
        wait_n(1);
        chk("R10 strobe one cycle", {7'd0, upd_o}, 8'h00);

        expect_code(8'hFF, "R2");
        par_i = 8'hFF;
        wait_n(6);
        chk("R2 max", code_o, 8'hFF);
        expect_code(8'h00, "R2");
        par_i = 8'h00;
        wait_n(6);
        chk("R2 min", code_o, 8'h00);

        // R3 latched parallel
        expect_code(8'h42, "R3");
        par_i = 8'h42;
        wait_n(6);
        en_i = 1'b0;
        wait_n(6);
        par_i = 8'h99;
        wait_n(6);
        chk("R3 pins ignored while enable low", code_o, 8'h42);
        expect_code(8'h99, "R3");
        en_i = 1'b1;
        wait_n(6);
        en_i = 1'b0;
        wait_n(6);
        chk("R3 captured at fall", code_o, 8'h99);
        par_i = 8'h01;
        wait_n(6);
        chk("R3 held after fall", code_o, 8'h99);

        // R9 mode change while enabled
        expect_code(8'h01, "R9");
        en_i = 1'b1;
        wait_n(6);
        mode_i = 1'b0;
        sdi_i  = 1'b0;
        for (int k = 0; k < 3; k++) begin
            sclk_i = 1'b1; wait_n(4);
            sclk_i = 1'b0; wait_n(4);
        end
        expect_code(8'h5A, "R9");
        par_i = 8'h5A;
        wait_n(6);
        chk("R9 still parallel", code_o, 8'h5A);
        chk("R9 oe stays low", {7'd0, sdo_oe_o}, 8'h00);
        en_i = 1'b0;
        wait_n(6);
        chk("R9 code after fall", code_o, 8'h5A);
        ser_write(8'hC3, "R9 no shift");

        wait_n(10);
        chk("R10 all strobes seen", expq.size() == 0 ? 8'h01 : 8'h00, 8'h01);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule